// File: doc/BRIEF.md
# Six-Channel Soft-Ramped Volume and Mute Stage

This block scales six signed 24-bit audio channels by a per-channel attenuation level and by a shared soft-mute factor. Each channel has an 8-bit level code. The gain applied to a channel does not jump to a newly written code. At each sample strobe it walks one code toward the code, at a pace chosen by a 2-bit speed select. The pace is set so that a walk across the whole range takes a fixed number of sample periods.

A separate mute ramp fades all channels to silence over 1024 sample periods. Releasing mute fades them back over the same span, and a release in mid-fade reverses from the point reached. A run-enable input acts as an internal reset. While it is low, every channel plays at unity gain and the mute ramp is cleared. The codes on the input pins are left untouched, so they apply again once the input returns high. An asynchronous power-down clears the whole stage.

The stage sits after serial capture and before interpolation. It is clocked by the system clock and advances only on the one-cycle sample strobe.

Top module: `soft_volume_stage`

## Requirements
- R1: Code c (0..255) gives gain g(c). g(0) = 0. For c > 0, let n = 255 - c. Then g(c) = round(32768 * 2^(-(n mod 12)/12)) shifted right by floor(n/12), in Q15. Code 255 is unity, each code below it is about 0.5 dB quieter, and code 0 silences the channel.
- R2: Let s be the input sample and m the mute count. The output is (s * G + 16384) >>> 15, clamped to the signed 24-bit range, where G = floor(g(level) * (1024 - m) / 1024).
- R3: `sampleOut` changes only on a clock edge where `fsStrobe` is high. It then uses the level and mute count held before that edge, and it holds its value between strobes.
- R4: The span P is 7424 for `rampSel` 0, 1061 for 1, and 256 for 2 and 3. A level ramping from a toward its code has moved floor(255*k/P) codes after k strobes, until it reaches the code. It moves at most one code per strobe and never moves without a strobe.
- R5: The mute count m rises by one per strobe while `muteReq` is high, stopping at 1024. It falls by one per strobe while `muteReq` is low, stopping at 0. A change of `muteReq` in mid-fade reverses from the current count, and the mute factor multiplies with the channel gain.
- R6: `muteDone` is high exactly when the mute count is 1024.
- R7: While `runEn` is low, every level is forced to 255 and the mute count to 0 on each clock, and `muteReq` has no effect. When `runEn` goes high again, the levels ramp from 255 toward the codes on `levelCode`.
- R8: While `rstN` is low (asynchronous), `sampleOut` is 0, `muteDone` is 0, all levels are 255 and the mute count is 0.
- R9: Channel i takes its code from `levelCode[8*i+7:8*i]`, its input from `sampleIn[24*i+23:24*i]`, and drives `sampleOut[24*i+23:24*i]`. The code of one channel has no effect on the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low power-down |
| runEn | input | 1 | Internal run enable; low forces unity gain and clears mute |
| fsStrobe | input | 1 | One-cycle pulse per sample period |
| rampSel | input | 2 | Ramp speed select |
| muteReq | input | 1 | Soft-mute request |
| levelCode | input | 48 | Six 8-bit level codes, channel 0 in the low byte |
| sampleIn | input | 144 | Six signed 24-bit input samples |
| sampleOut | output | 144 | Six signed 24-bit scaled samples |
| muteDone | output | 1 | Mute ramp has reached full attenuation |

## Verification
Assertions check on every cycle that each level moves by at most one code and only on a strobe, that run-enable low pins the level at the top code, and that the output register holds between strobes. They also check that the mute count steps up or down by one per strobe according to the request. Only the bench scenarios can show the exact ramp timing for each speed: the level one strobe before the end of a full-range walk, and the level when the walk completes. The same holds for the Q15 gain values of scattered codes, the rounding and clamping of the product, the reversal point of an interrupted mute, and the return to the programmed codes after run-enable or power-down.

// File: rtl/vol_pkg.sv
package vol_pkg;
  localparam int GAIN_W = 16;
  localparam int GAIN_FRAC = 15;
  localparam int STEPS_PER_OCTAVE = 12;

  typedef struct packed {
    logic tick;   // sample-period advance
    logic hold;   // run-enable low: force unity and clear mute
  } ctrlStrobes_t;

  // Q15 mantissa for a fraction of an octave, 2^(-k/12)
  function automatic logic [GAIN_W-1:0] stepMantissa(input int unsigned k);
    case (k)
      0:  return 16'd32768;
      1:  return 16'd30929;
      2:  return 16'd29193;
      3:  return 16'd27554;
      4:  return 16'd26008;
      5:  return 16'd24548;
      6:  return 16'd23170;
      7:  return 16'd21870;
      8:  return 16'd20643;
      9:  return 16'd19484;
      10: return 16'd18390;
      default: return 16'd17358;
    endcase
  endfunction

  // Gain for a number of attenuation steps below unity
  function automatic logic [GAIN_W-1:0] attenGain(input int unsigned steps);
    int unsigned oct;
    logic [GAIN_W-1:0] mant;
    oct  = steps / STEPS_PER_OCTAVE;
    mant = stepMantissa(steps % STEPS_PER_OCTAVE);
    if (oct >= GAIN_W) return '0;
    return mant >> oct;
  endfunction
endpackage

// File: rtl/volCtrl.sv
module volCtrl
  import vol_pkg::*;
#(
  parameter int MUTE_SPAN = 1024,
  localparam int MUTE_W = $clog2(MUTE_SPAN + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              fsStrobe,
  input  logic              muteReq,
  output ctrlStrobes_t      strobes,
  output logic [MUTE_W-1:0] muteScale,
  output logic              muteDone
);
  localparam logic [MUTE_W-1:0] FULL = MUTE_W'(MUTE_SPAN);

  logic [MUTE_W-1:0] muteCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      muteCnt <= '0;
    end else if (!runEn) begin
      muteCnt <= '0;
    end else if (fsStrobe) begin
      if (muteReq && muteCnt != FULL)
        muteCnt <= muteCnt + 1'b1;
      else if (!muteReq && muteCnt != '0)
        muteCnt <= muteCnt - 1'b1;
    end
  end

  always_comb begin
    strobes.tick = fsStrobe;
    strobes.hold = !runEn;
  end

  assign muteScale = FULL - muteCnt;
  assign muteDone  = (muteCnt == FULL);

  // R5
  mute_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fsStrobe && runEn && muteReq && muteCnt != FULL) |=> muteCnt == $past(muteCnt) + 1'b1);
  // R5
  mute_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fsStrobe && runEn && !muteReq && muteCnt != '0) |=> muteCnt == $past(muteCnt) - 1'b1);
  // R7
  mute_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> muteCnt == '0);
endmodule

// File: rtl/volChannel.sv
module volChannel
  import vol_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CODE_W = 8,
  parameter int ACC_W = 13,
  parameter int MUTE_W = 11,
  parameter int MUTE_SHIFT = 10
)(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [ACC_W-1:0]    span,
  input  logic [CODE_W-1:0]   target,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [MUTE_W-1:0]   muteScale,
  output logic [SAMPLE_W-1:0] sampleOut
);
  localparam logic [CODE_W-1:0] TOP_CODE = '1;
  localparam logic [ACC_W:0] STEP = (ACC_W + 1)'((1 << CODE_W) - 1);
  localparam int PW = SAMPLE_W + GAIN_W + 1;
  localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (SAMPLE_W - 1)) - 64'sd1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

  logic [CODE_W-1:0] level, levelNext;
  logic [ACC_W-1:0]  acc;
  logic [ACC_W:0]    accSum, accLeft;
  logic              reach;

  // ramp step: accumulate full range per strobe, step when a span is covered
  always_comb begin
    accSum    = {1'b0, acc} + STEP;
    accLeft   = accSum - {1'b0, span};
    reach     = (accSum >= {1'b0, span});
    levelNext = level;
    if (reach) levelNext = (target > level) ? level + 1'b1 : level - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level <= TOP_CODE;
      acc   <= '0;
    end else if (strobes.hold) begin
      level <= TOP_CODE;
      acc   <= '0;
    end else if (strobes.tick) begin
      if (level == target) begin
        acc <= '0;
      end else begin
        level <= levelNext;
        if (levelNext == target) acc <= '0;
        else if (reach)          acc <= accLeft[ACC_W-1:0];
        else                     acc <= accSum[ACC_W-1:0];
      end
    end
  end

  // gain and scaling
  logic [GAIN_W-1:0]        codeGain, mixGain;
  logic [GAIN_W+MUTE_W-1:0] mixProd;
  logic signed [PW-1:0]     prod, rounded, scaled;
  logic [SAMPLE_W-1:0]      satVal;
  int unsigned              steps;

  always_comb begin
    steps    = 32'(TOP_CODE) - 32'(level);
    codeGain = (level == '0) ? '0 : attenGain(steps);
    mixProd  = (GAIN_W + MUTE_W)'(codeGain) * (GAIN_W + MUTE_W)'(muteScale);
    mixGain  = GAIN_W'(mixProd >> MUTE_SHIFT);
    prod     = PW'($signed(sampleIn)) * PW'($signed({1'b0, mixGain}));
    rounded  = prod + PW'(1 << (GAIN_FRAC - 1));
    scaled   = rounded >>> GAIN_FRAC;
    if (scaled > MAXV)      satVal = {1'b0, {(SAMPLE_W-1){1'b1}}};
    else if (scaled < MINV) satVal = {1'b1, {(SAMPLE_W-1){1'b0}}};
    else                    satVal = scaled[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             sampleOut <= '0;
    else if (strobes.tick) sampleOut <= satVal;
  end

  // R4
  step_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.hold |=> ({1'b0, level} == {1'b0, $past(level)} ||
                       {1'b0, level} == {1'b0, $past(level)} + 1'b1 ||
                       {1'b0, level} + 1'b1 == {1'b0, $past(level)}));
  // R4
  no_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.tick && !strobes.hold) |=> $stable(level));
  // R7
  hold_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hold |=> level == TOP_CODE);
  // R3
  out_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.tick |=> $stable(sampleOut));
endmodule

// File: rtl/volDatapath.sv
module volDatapath
  import vol_pkg::*;
#(
  parameter int CHANNELS = 6,
  parameter int SAMPLE_W = 24,
  parameter int CODE_W = 8,
  parameter int SLOW_SPAN = 7424,
  parameter int MID_SPAN = 1061,
  parameter int FAST_SPAN = 256,
  parameter int MUTE_W = 11,
  parameter int MUTE_SHIFT = 10
)(
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobes_t                 strobes,
  input  logic [1:0]                   rampSel,
  input  logic [MUTE_W-1:0]            muteScale,
  input  logic [CHANNELS*CODE_W-1:0]   levelCode,
  input  logic [CHANNELS*SAMPLE_W-1:0] sampleIn,
  output logic [CHANNELS*SAMPLE_W-1:0] sampleOut
);
  localparam int MAX_A = (SLOW_SPAN > MID_SPAN) ? SLOW_SPAN : MID_SPAN;
  localparam int MAX_SPAN = (MAX_A > FAST_SPAN) ? MAX_A : FAST_SPAN;
  localparam int ACC_W = $clog2(MAX_SPAN + (1 << CODE_W));

  logic [ACC_W-1:0] span;

  always_comb begin
    case (rampSel)
      2'd0:    span = ACC_W'(SLOW_SPAN);
      2'd1:    span = ACC_W'(MID_SPAN);
      default: span = ACC_W'(FAST_SPAN);
    endcase
  end

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    volChannel #(
      .SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W), .ACC_W(ACC_W),
      .MUTE_W(MUTE_W), .MUTE_SHIFT(MUTE_SHIFT)
    ) u_chan (
      .clk      (clk),
      .rstN     (rstN),
      .strobes  (strobes),
      .span     (span),
      .target   (levelCode[ch*CODE_W +: CODE_W]),
      .sampleIn (sampleIn[ch*SAMPLE_W +: SAMPLE_W]),
      .muteScale(muteScale),
      .sampleOut(sampleOut[ch*SAMPLE_W +: SAMPLE_W])
    );
  end
endmodule

// File: rtl/soft_volume_stage.sv
module soft_volume_stage
  import vol_pkg::*;
#(
  parameter int CHANNELS = 6,
  parameter int SAMPLE_W = 24,
  parameter int CODE_W = 8,
  parameter int SLOW_SPAN = 7424,
  parameter int MID_SPAN = 1061,
  parameter int FAST_SPAN = 256,
  parameter int MUTE_SPAN = 1024
)(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         runEn,
  input  logic                         fsStrobe,
  input  logic [1:0]                   rampSel,
  input  logic                         muteReq,
  input  logic [CHANNELS*CODE_W-1:0]   levelCode,
  input  logic [CHANNELS*SAMPLE_W-1:0] sampleIn,
  output logic [CHANNELS*SAMPLE_W-1:0] sampleOut,
  output logic                         muteDone
);
  localparam int MUTE_W = $clog2(MUTE_SPAN + 1);
  localparam int MUTE_SHIFT = $clog2(MUTE_SPAN);

  ctrlStrobes_t      strobes;
  logic [MUTE_W-1:0] muteScale;

  volCtrl #(.MUTE_SPAN(MUTE_SPAN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .runEn    (runEn),
    .fsStrobe (fsStrobe),
    .muteReq  (muteReq),
    .strobes  (strobes),
    .muteScale(muteScale),
    .muteDone (muteDone)
  );

  volDatapath #(
    .CHANNELS(CHANNELS), .SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W),
    .SLOW_SPAN(SLOW_SPAN), .MID_SPAN(MID_SPAN), .FAST_SPAN(FAST_SPAN),
    .MUTE_W(MUTE_W), .MUTE_SHIFT(MUTE_SHIFT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .rampSel  (rampSel),
    .muteScale(muteScale),
    .levelCode(levelCode),
    .sampleIn (sampleIn),
    .sampleOut(sampleOut)
  );
endmodule

// File: tb/sim_soft_volume_stage.sv
module sim_soft_volume_stage;
  localparam int CLK_PERIOD = 10;
  localparam int CH = 6;
  localparam int SW = 24;
  localparam int CW = 8;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0, rstN = 1'b0, runEn = 1'b0, fsStrobe = 1'b0, muteReq = 1'b0;
  logic [1:0] rampSel = 2'd3;
  logic [CH*CW-1:0] levelCode = '1;
  logic [CH*SW-1:0] sampleIn = '0;
  logic [CH*SW-1:0] sampleOut;
  logic muteDone;

  soft_volume_stage u0 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .fsStrobe(fsStrobe), .rampSel(rampSel),
    .muteReq(muteReq), .levelCode(levelCode), .sampleIn(sampleIn),
    .sampleOut(sampleOut), .muteDone(muteDone)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { longint expv[CH]; string tag; } expItem_t;
  expItem_t expQ[$];

  int testsRun = 0, testsFailed = 0, seq = 0;
  int mdlLevel[CH];
  int mdlMute = 0;
  bit finished = 0;

  longint pattern[8] = '{64'sd8388607, -64'sd8388608, 64'sd1, -64'sd1, 64'sd3,
                         64'sd1193046, -64'sd2385068, 64'sd4194304};

  function automatic void tally(bit ok, string tag, string what, longint act, longint expv);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endfunction

  // R1: Q15 gain of a code
  function automatic longint refGain(int code);
    int n, k, oct;
    real m;
    if (code == 0) return 0;
    n = 255 - code; k = n % 12; oct = n / 12;
    m = 32768.0 * (2.0 ** (-real'(k) / 12.0));
    return longint'($rtoi(m + 0.5)) >>> oct;
  endfunction

  // R2: rounded, clamped product
  function automatic longint refOut(longint s, int code, int m);
    longint g, v;
    g = (refGain(code) * (1024 - m)) >>> 10;
    v = (s * g + 16384) >>> 15;
    if (v > 8388607) v = 8388607;
    if (v < -8388608) v = -8388608;
    return v;
  endfunction

  // R4: codes travelled after k strobes
  function automatic int rampPos(int k, int span);
    return (255 * k) / span;
  endfunction

  task automatic setCodes(int c0, int c1, int c2, int c3, int c4, int c5);
    int v[CH];
    v = '{c0, c1, c2, c3, c4, c5};
    for (int c = 0; c < CH; c++) levelCode[c*CW +: CW] = CW'(v[c]);
  endtask

  task automatic setMdl(int v);
    for (int c = 0; c < CH; c++) mdlLevel[c] = v;
  endtask

  // driver: one strobe, optionally pushes expected outputs
  task automatic pulse(bit doCheck, string tag);
    expItem_t it;
    @(negedge clk);
    for (int c = 0; c < CH; c++) begin
      sampleIn[c*SW +: SW] = SW'(pattern[(seq + c) % 8]);
      it.expv[c] = refOut(pattern[(seq + c) % 8], mdlLevel[c], mdlMute);
    end
    seq++;
    fsStrobe = 1'b1;
    @(posedge clk);
    if (doCheck) begin
      it.tag = tag;
      expQ.push_back(it);
    end
    @(negedge clk);
    fsStrobe = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) pulse(1'b0, "");
  endtask

  // monitor: compares after each rising edge
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      while (expQ.size() > 0) begin
        it = expQ.pop_front();
        for (int c = 0; c < CH; c++)
          tally(longint'($signed(sampleOut[c*SW +: SW])) == it.expv[c], it.tag,
                $sformatf("channel %0d", c),
                longint'($signed(sampleOut[c*SW +: SW])), it.expv[c]);
      end
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    tally(1'b0, "watchdog", "run did not end", 0, 1);
    report();
  end

  // full-range walk from 0 to 255 at a given speed
  task automatic rampUp(int sel, int span, string tag);
    rampSel = 2'd3;
    setCodes(0, 0, 0, 0, 0, 0);
    idle(260);
    rampSel = 2'(sel);
    setCodes(255, 255, 255, 255, 255, 255);
    idle(span / 2);
    setMdl(rampPos(span / 2, span));
    pulse(1'b1, {tag, " midpoint"});
    idle(span - 1 - (span / 2 + 1));
    setMdl(rampPos(span - 1, span));
    pulse(1'b1, {tag, " one before end"});
    setMdl(255);
    pulse(1'b1, {tag, " end"});
  endtask

  initial begin
    logic [CH*SW-1:0] snap;
    setMdl(255);
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    tally(sampleOut == '0, "R8", "sampleOut in reset", longint'(sampleOut[SW-1:0]), 0);
    tally(muteDone == 1'b0, "R8", "muteDone in reset", longint'(muteDone), 0);
    @(negedge clk);
    rstN = 1'b1; runEn = 1'b1;

    // R1 unity, R2 clamp/round at unity
    repeat (3) pulse(1'b1, "R1 unity");

    // R1 R9 per-channel gains
    rampSel = 2'd3;
    setCodes(255, 243, 254, 1, 0, 128);
    idle(260);
    mdlLevel = '{255, 243, 254, 1, 0, 128};
    repeat (4) pulse(1'b1, "R1 R9 per-channel gain");

    // R3 output holds without strobe
    @(negedge clk);
    snap = sampleOut;
    sampleIn = ~sampleIn;
    repeat (5) @(negedge clk);
    tally(sampleOut == snap, "R3", "output moved without strobe",
          longint'(sampleOut[SW-1:0]), longint'(snap[SW-1:0]));

    // R4 ramp timing for each speed
    rampUp(2, 256, "R4 sel2");
    rampUp(3, 256, "R4 sel3");
    rampUp(1, 1061, "R4 sel1");
    rampUp(0, 7424, "R4 sel0");

    // R5 R6 soft mute
    rampSel = 2'd3;
    muteReq = 1'b1;
    idle(512);
    mdlMute = 512;
    pulse(1'b1, "R5 half mute");
    idle(510);
    tally(muteDone == 1'b0, "R6", "muteDone at 1023", longint'(muteDone), 0);
    idle(1);
    tally(muteDone == 1'b1, "R6", "muteDone at 1024", longint'(muteDone), 1);
    mdlMute = 1024;
    pulse(1'b1, "R5 full mute");
    muteReq = 1'b0;
    idle(300);
    tally(muteDone == 1'b0, "R6", "muteDone after release", longint'(muteDone), 0);
    mdlMute = 724;
    pulse(1'b1, "R5 release");
    muteReq = 1'b1;
    idle(100);
    muteReq = 1'b0;
    idle(50);
    mdlMute = 773;
    pulse(1'b1, "R5 reversal");
    idle(800);
    mdlMute = 0;
    pulse(1'b1, "R5 back to unity");

    // R5 combined with code attenuation
    setCodes(243, 243, 243, 243, 243, 243);
    idle(20);
    muteReq = 1'b1;
    idle(512);
    setMdl(243);
    mdlMute = 512;
    pulse(1'b1, "R5 combined with code");
    muteReq = 1'b0;
    idle(600);
    mdlMute = 0;

    // R7 run-enable low
    @(negedge clk);
    runEn = 1'b0;
    muteReq = 1'b1;
    repeat (2) @(negedge clk);
    setMdl(255);
    pulse(1'b1, "R7 unity while held");
    pulse(1'b1, "R7 mute ignored while held");
    tally(muteDone == 1'b0, "R7", "muteDone while held", longint'(muteDone), 0);
    muteReq = 1'b0;
    @(negedge clk);
    runEn = 1'b1;
    pulse(1'b1, "R7 resume from top");
    idle(12);
    setMdl(243);
    pulse(1'b1, "R7 codes restored");

    // R8 power-down mid-ramp
    rampSel = 2'd0;
    setCodes(0, 0, 0, 0, 0, 0);
    idle(100);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    tally(sampleOut == '0, "R8", "sampleOut after power-down", longint'(sampleOut[SW-1:0]), 0);
    tally(muteDone == 1'b0, "R8", "muteDone after power-down", longint'(muteDone), 0);
    @(negedge clk);
    rstN = 1'b1;
    setMdl(255);
    pulse(1'b1, "R8 restart at top");

    repeat (3) @(posedge clk);
    tally(expQ.size() == 0, "scoreboard", "pending items", expQ.size(), 0);
    report();
  end
endmodule